// File: doc/BRIEF.md
# Deep Power-Down Wakeup Controller

This block sits in the always-on domain of a small microcontroller. It decides when the chip enters deep power-down and when it comes back out. Software arms entry by setting an enable bit. The core then executes a sleep instruction, which reaches the block as a one-cycle strobe, and the block raises a power-down request that holds for the whole stay in power-down. A debug-port block bit can veto every entry.

The block can leave power-down in three ways:
- a falling edge on an active-low wakeup pin;
- expiry of a timer that counts ticks of a low-speed oscillator;
- a power-on-reset indication.

After an exit, the block records in read-only flags which source ended the stay. At the moment of entry it captures two values: a snapshot of the timer setting, and an 8-bit software value that is kept across the power-down. The cause flags are cleared at that same moment. A pin or timer exit produces a single-cycle wakeup pulse.

The register port is a simple word-wide write strobe with a combinational read. The three registers are:
- control, at address 0;
- status, at address 1, read-only;
- retained state, at address 2.

Top module: `dpd_wake_ctrl`

## Requirements
- R1: The power-down request (`pdReq`) rises on the clock edge after a cycle where `sleepStrobe` is 1 and control bit 0 (enable) is 1. Without both, it stays low.
- R2: While control bit 3 (debug block) is 1, a sleep strobe never raises `pdReq`.
- R3: Control bits [4 +: SEL_W] select the timer delay. Bit k gives 2^(BASE_SHIFT+k) low-speed ticks. When several bits are set, the lowest set bit wins. When none are set, no timed wakeup occurs.
- R4: While control bit 2 (oscillator off in power-down) is 1, no timed wakeup occurs.
- R5: A pin wakeup needs a high-to-low transition on `wakePinN`, taken through a two-flop synchronizer, while in power-down. It also needs control bit 1 (pin off) to be 0. When bit 1 is 1, or outside power-down, the transition has no effect.
- R6: Status bit 0 is the pin wakeup flag, bit 1 the timer wakeup flag and bit 2 the power-on flag. Each is set by its own cause, and all three are cleared at power-down entry.
- R7: Status bits [4 +: SEL_W] hold a copy of the timer select field, taken at power-down entry.
- R8: Address 2 bits [STATE_W-1:0] are software-writable. At power-down entry they are copied to bits [2*STATE_W-1:STATE_W], and that copy survives a pin or timer wakeup. A `porIn` pulse forces the run state, sets the power-on flag and clears the copy.
- R9: A pin or timer exit drops `pdReq` and gives a `wakePulse` exactly one cycle long on the same edge. Status bit 3 shows the power-down state.
- R10: After `rstN`, every register reads 0, and `pdReq` and `wakePulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data (combinational) |
| sleepStrobe | input | 1 | Core sleep-instruction strobe |
| porIn | input | 1 | Power-on-reset indication |
| wakePinN | input | 1 | Active-low wakeup pin, asynchronous |
| lsTick | input | 1 | One-cycle tick of the low-speed oscillator |
| pdReq | output | 1 | Power-down request, high while in power-down |
| wakePulse | output | 1 | Single-cycle wakeup pulse |

## Verification
The bench builds the block with BASE_SHIFT=2, SEL_W=4 and STATE_W=8. The four timer delays then become 4, 8, 16 and 32 ticks, so the bench can sweep all 16 select codes and count ticks up to the exact wakeup tick. With these delays, the retained byte, the snapshot and the flag clearing are checked on every entry of the sweep. The bench also covers:
- oscillator-off and pin-off configurations;
- pin edges while running;
- the debug veto;
- power-on exit.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_DPD = 1'b1} dpdState_t;

  typedef struct packed {
    logic enterDpd;
    logic wakePin;
    logic wakeTimer;
    logic porEvt;
  } dpdStrobes_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_KEEP = 2;
endpackage

// File: rtl/dpd_ctrl.sv
module dpd_ctrl
  import dpd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepStrobe,
  input  logic        porIn,
  input  logic        wakePinN,
  input  logic        dpdEn,
  input  logic        dbgBlock,
  input  logic        pinOff,
  input  logic        timerDone,
  output dpdStrobes_t strobes,
  output logic        inDpd,
  output logic        pdReq,
  output logic        wakePulse
);
  dpdState_t state, nextState;
  logic [2:0] pinSync;
  logic       pinFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= 3'b111;
    else       pinSync <= {pinSync[1:0], wakePinN};
  end
  assign pinFall = pinSync[2] & ~pinSync[1];

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (porIn) begin
      strobes.porEvt = 1'b1;
      nextState      = ST_RUN;
    end else if (state == ST_RUN) begin
      if (sleepStrobe && dpdEn && !dbgBlock) begin
        strobes.enterDpd = 1'b1;
        nextState        = ST_DPD;
      end
    end else begin
      if (pinFall && !pinOff) begin
        strobes.wakePin = 1'b1;
        nextState       = ST_RUN;
      end else if (timerDone) begin
        strobes.wakeTimer = 1'b1;
        nextState         = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      wakePulse <= 1'b0;
    end else begin
      state     <= nextState;
      wakePulse <= strobes.wakePin | strobes.wakeTimer;
    end
  end

  assign inDpd = (state == ST_DPD);
  assign pdReq = inDpd;

  // R9: the wake pulse lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
  // R9: a wake pulse comes with the run state
  a_r9_wake_returns_run: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> !pdReq);
  // R1: entry needs the sleep strobe and the enable bit
  a_r1_entry_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdReq) |-> $past(sleepStrobe && dpdEn));
  // R2: the debug block bit vetoes entry
  a_r2_debug_veto: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdReq) |-> !$past(dbgBlock));
  // R5: the pin causes no exit while it is switched off
  a_r5_pin_off_no_wake: assert property (@(posedge clk) disable iff (!rstN)
    (pinOff && !timerDone && !porIn && inDpd) |=> pdReq);
endmodule

// File: rtl/dpd_datapath.sv
module dpd_datapath
  import dpd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STATE_W    = 8,
  parameter int SEL_W      = 4,
  parameter int BASE_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              lsTick,
  input  dpdStrobes_t       strobes,
  input  logic              inDpd,
  output logic              dpdEn,
  output logic              dbgBlock,
  output logic              pinOff,
  output logic              timerDone
);
  localparam int CNT_W   = BASE_SHIFT + SEL_W;
  localparam int SEL_LSB = 4;

  logic               oscOff;
  logic [SEL_W-1:0]   timerSel, timerSnap;
  logic               pinFlag, tmrFlag, porFlag;
  logic [STATE_W-1:0] stateWr, stateKept;
  logic [CNT_W-1:0]   tickCnt, lastCnt;
  logic               timerRun;

  function automatic logic [CNT_W-1:0] lastCountFor(input logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] v;
    v = '0;
    for (int k = SEL_W - 1; k >= 0; k--)
      if (s[k]) v = CNT_W'((64'd1 << (BASE_SHIFT + k)) - 64'd1);
    return v;
  endfunction

  // control and retained-state write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpdEn    <= 1'b0;
      pinOff   <= 1'b0;
      oscOff   <= 1'b0;
      dbgBlock <= 1'b0;
      timerSel <= '0;
      stateWr  <= '0;
    end else if (regWe) begin
      if (regAddr == 2'(ADDR_CTRL)) begin
        dpdEn    <= regWdata[0];
        pinOff   <= regWdata[1];
        oscOff   <= regWdata[2];
        dbgBlock <= regWdata[3];
        timerSel <= regWdata[SEL_LSB +: SEL_W];
      end else if (regAddr == 2'(ADDR_KEEP)) begin
        stateWr <= regWdata[STATE_W-1:0];
      end
    end
  end

  // state captured at entry and cause flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinFlag   <= 1'b0;
      tmrFlag   <= 1'b0;
      porFlag   <= 1'b0;
      timerSnap <= '0;
      stateKept <= '0;
    end else begin
      if (strobes.enterDpd) begin
        pinFlag   <= 1'b0;
        tmrFlag   <= 1'b0;
        porFlag   <= 1'b0;
        timerSnap <= timerSel;
        stateKept <= stateWr;
      end
      if (strobes.wakePin)   pinFlag <= 1'b1;
      if (strobes.wakeTimer) tmrFlag <= 1'b1;
      if (strobes.porEvt) begin
        porFlag   <= 1'b1;
        stateKept <= '0;
      end
    end
  end

  // wakeup timer on low-speed ticks
  assign lastCnt  = lastCountFor(timerSnap);
  assign timerRun = inDpd && !oscOff && (|timerSnap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tickCnt <= '0;
    else if (strobes.enterDpd)  tickCnt <= '0;
    else if (timerRun && lsTick) tickCnt <= tickCnt + 1'b1;
  end

  assign timerDone = timerRun && lsTick && (tickCnt == lastCnt);

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      2'(ADDR_CTRL): begin
        regRdata[0] = dpdEn;
        regRdata[1] = pinOff;
        regRdata[2] = oscOff;
        regRdata[3] = dbgBlock;
        regRdata[SEL_LSB +: SEL_W] = timerSel;
      end
      2'(ADDR_STAT): begin
        regRdata[0] = pinFlag;
        regRdata[1] = tmrFlag;
        regRdata[2] = porFlag;
        regRdata[3] = inDpd;
        regRdata[SEL_LSB +: SEL_W] = timerSnap;
      end
      2'(ADDR_KEEP): begin
        regRdata[STATE_W-1:0]       = stateWr;
        regRdata[STATE_W +: STATE_W] = stateKept;
      end
      default: regRdata = '0;
    endcase
  end

  // R6: entry leaves all cause flags clear
  a_r6_flags_clear_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterDpd |=> !(pinFlag || tmrFlag || porFlag));
  // R7: the snapshot equals the select field present at entry
  a_r7_snapshot_at_entry: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterDpd |=> timerSnap == $past(timerSel));
  // R8: a power-on event clears the retained byte
  a_r8_por_clears_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.porEvt |=> stateKept == '0);
  // R4: no timed exit while the oscillator is off
  a_r4_no_timer_when_off: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |-> !oscOff);
  // R3: the counter never runs past the selected limit
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    timerRun |-> tickCnt <= lastCnt);
endmodule

// File: rtl/dpd_wake_ctrl.sv
module dpd_wake_ctrl
  import dpd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STATE_W    = 8,
  parameter int SEL_W      = 4,
  parameter int BASE_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sleepStrobe,
  input  logic              porIn,
  input  logic              wakePinN,
  input  logic              lsTick,
  output logic              pdReq,
  output logic              wakePulse
);
  dpdStrobes_t strobes;
  logic inDpd, dpdEn, dbgBlock, pinOff, timerDone;

  dpd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe), .porIn(porIn),
    .wakePinN(wakePinN), .dpdEn(dpdEn), .dbgBlock(dbgBlock), .pinOff(pinOff),
    .timerDone(timerDone), .strobes(strobes), .inDpd(inDpd), .pdReq(pdReq),
    .wakePulse(wakePulse)
  );

  dpd_datapath #(
    .DATA_W(DATA_W), .STATE_W(STATE_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lsTick(lsTick),
    .strobes(strobes), .inDpd(inDpd), .dpdEn(dpdEn), .dbgBlock(dbgBlock),
    .pinOff(pinOff), .timerDone(timerDone)
  );
endmodule

// File: tb/dpd_wake_ctrl_bench.sv
module dpd_wake_ctrl_bench;
  localparam int DATA_W = 32, STATE_W = 8, SEL_W = 4, BASE_SHIFT = 2;
  localparam int MAX_TICKS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic sleepStrobe = 1'b0, porIn = 1'b0, wakePinN = 1'b1, lsTick = 1'b0;
  logic pdReq, wakePulse;

  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  dpd_wake_ctrl #(.DATA_W(DATA_W), .STATE_W(STATE_W), .SEL_W(SEL_W),
                  .BASE_SHIFT(BASE_SHIFT)) u_dpd_wake_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sleepStrobe(sleepStrobe),
    .porIn(porIn), .wakePinN(wakePinN), .lsTick(lsTick), .pdReq(pdReq),
    .wakePulse(wakePulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    regAddr = 2'(a); regWdata = DATA_W'(d); regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    regAddr = 2'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic sleepPulse();
    sleepStrobe = 1'b1;
    @(negedge clk);
    sleepStrobe = 1'b0;
  endtask

  task automatic tick();
    lsTick = 1'b1;
    @(negedge clk);
    lsTick = 1'b0;
  endtask

  // drops the pin, returns the cycle count until wakePulse (0 = none in 8)
  task automatic pinEdge(output int lat);
    lat = 0;
    wakePinN = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (wakePulse && lat == 0) lat = c;
    end
    wakePinN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int expTicks(input int sel);
    for (int k = 0; k < SEL_W; k++) if (sel[k]) return 1 << (BASE_SHIFT + k);
    return 0;
  endfunction

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int v, lat, wakeAt, keepVal;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 3; a++) begin
      rd(a, v); chk(v == 0, "R10 register reset", v, 0);
    end
    chk(pdReq == 0 && wakePulse == 0, "R10 outputs low", int'(pdReq), 0);

    // R1 no entry when enable is clear
    wr(0, 0); sleepPulse();
    chk(pdReq == 0, "R1 sleep without enable", int'(pdReq), 0);
    // R1 no entry without a sleep strobe
    wr(0, 1); repeat (3) @(negedge clk);
    chk(pdReq == 0, "R1 enable without sleep", int'(pdReq), 0);
    // R2 debug block vetoes entry
    wr(0, 32'h9); sleepPulse();
    chk(pdReq == 0, "R2 debug veto", int'(pdReq), 0);

    // R3 sweep of every timer select code
    for (int sel = 0; sel < (1 << SEL_W); sel++) begin
      keepVal = (sel * 17 + 3) & 8'hFF;
      wr(2, keepVal);
      wr(0, (sel << 4) | 1);
      sleepPulse();
      chk(pdReq == 1, "R1 entry after sleep", int'(pdReq), 1);
      rd(1, v);
      chk((v & 7) == 0, "R6 flags cleared at entry", v & 7, 0);
      chk(((v >> 4) & 15) == sel, "R7 snapshot", (v >> 4) & 15, sel);
      chk(((v >> 3) & 1) == 1, "R9 status shows power-down", (v >> 3) & 1, 1);
      rd(2, v);
      chk(((v >> 8) & 8'hFF) == keepVal, "R8 retained at entry", (v >> 8) & 8'hFF, keepVal);
      wakeAt = 0;
      for (int t = 1; t <= MAX_TICKS && wakeAt == 0; t++) begin
        tick();
        if (wakePulse) wakeAt = t;
        @(negedge clk);
        if (wakeAt != 0)
          chk(wakePulse == 0, "R9 pulse one cycle", int'(wakePulse), 0);
      end
      chk(wakeAt == expTicks(sel), "R3 timer delay", wakeAt, expTicks(sel));
      if (sel != 0) begin
        chk(pdReq == 0, "R9 run after wake", int'(pdReq), 0);
        rd(1, v);
        chk((v & 7) == 2, "R6 timer flag", v & 7, 2);
      end else begin
        chk(pdReq == 1, "R3 no timer when none selected", int'(pdReq), 1);
        pinEdge(lat);
        chk(lat == 3, "R5 pin wake latency", lat, 3);
        rd(1, v);
        chk((v & 7) == 1, "R6 pin flag", v & 7, 1);
      end
      rd(2, v);
      chk(((v >> 8) & 8'hFF) == keepVal, "R8 retained after wake", (v >> 8) & 8'hFF, keepVal);
    end

    // R4 oscillator off: no timed wakeup
    wr(0, (1 << 4) | 4 | 1); sleepPulse();
    for (int t = 0; t < MAX_TICKS; t++) begin
      tick(); @(negedge clk);
      if (wakePulse) chk(0, "R4 wake while oscillator off", 1, 0);
    end
    chk(pdReq == 1, "R4 still down", int'(pdReq), 1);
    pinEdge(lat);
    chk(lat == 3 && pdReq == 0, "R5 pin wake with oscillator off", lat, 3);

    // R5 pin off: edge ignored in power-down, then power-on exit
    wr(2, 8'hA5);
    wr(0, 2 | 1); sleepPulse();
    pinEdge(lat);
    chk(lat == 0 && pdReq == 1, "R5 pin off ignored", lat, 0);
    rd(1, v);
    chk((v & 7) == 0, "R5 no flag when pin off", v & 7, 0);
    porIn = 1'b1; @(negedge clk); porIn = 1'b0;
    chk(pdReq == 0 && wakePulse == 0, "R8 power-on forces run", int'(pdReq), 0);
    rd(1, v);
    chk((v & 7) == 4, "R6 power-on flag", v & 7, 4);
    rd(2, v);
    chk(((v >> 8) & 8'hFF) == 0, "R8 power-on clears retained", (v >> 8) & 8'hFF, 0);

    // R5 pin edge while running has no effect
    wr(0, 1);
    pinEdge(lat);
    chk(lat == 0 && pdReq == 0, "R5 edge in run ignored", lat, 0);
    rd(1, v);
    chk((v & 7) == 4, "R5 flags unchanged in run", v & 7, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule